// File: doc/BRIEF.md
# Range Cache Maintenance Sequencer

This block is a memory-mapped engine that applies a clean-and-invalidate operation to every 128-byte cache line touched by a physical address range. Software programs a 64-bit start address and a 64-bit inclusive length. Each value is written as two 32-bit words. Software then writes the control register with its enable bit set. The enable bit stays set while the walk runs, and software polls it to learn when the operation is complete.

The engine visits the lines in ascending order. For each line it places the line address on a lookup port, and a combinational ownership and presence check answers with a hit flag. On a hit the engine raises a maintenance request on a valid/ready port and holds it until the request is accepted. On a miss the line is skipped without any sign to software, and the operation still finishes normally. The cache arrays and the ownership hash lie outside the block.

The control state machine has four states:
- WALK_IDLE: waits for a launch.
- WALK_PROBE: presents the current line on the lookup port.
- WALK_SEND: holds the maintenance request.
- WALK_DONE: retires the operation.

Its transitions are:
- launch with clean-and-invalidate type: WALK_IDLE to WALK_PROBE.
- launch with any other type: WALK_IDLE to WALK_DONE.
- lookup hit: WALK_PROBE to WALK_SEND.
- lookup miss on a line that is not the last: WALK_PROBE to WALK_PROBE, advancing one line.
- lookup miss on the last line: WALK_PROBE to WALK_DONE.
- request accepted on a line that is not the last: WALK_SEND to WALK_PROBE, advancing one line.
- request accepted on the last line: WALK_SEND to WALK_DONE.
- always: WALK_DONE to WALK_IDLE.

Top module: `cmo_range_walker`

## Requirements
- R1: After reset, every register reads 0, and `mreq_valid` and `done_pulse` are 0.
- R2: The register map is as follows. Offsets not listed here read 0.
  - 0x5004: control register. Bit 0 is enable, bit 1 is range mode, and bits 3:2 are the operation type.
  - 0x5008: start address, low word. 0x500C: start address, high word.
  - 0x5010: length, low word. 0x5014: length, high word.
  - Registers read back what was last written. A control write with bit 0 clear only stores the fields and starts nothing.
- R3: A control write with bit 0 set while enable reads 0 launches an operation. Enable then reads 1 until the operation completes.
- R4: With type 1 (clean-and-invalidate) and range mode set, the engine visits line addresses in ascending steps of 128. The first line is the start address with bits 6:0 cleared. The last line is (start + length) with bits 6:0 cleared. Addition is 64-bit and carries across the word boundary.
- R5: With type 1 and range mode clear, only the line containing the start address is visited.
- R6: A visited line whose `lookup_hit` is 0 produces no request, and the operation still completes.
- R7: A request whose `mreq_ready` is low keeps `mreq_valid` high and `mreq_addr` unchanged. No line is skipped under back-pressure.
- R8: Type values 0, 2 and 3 complete without issuing any request.
- R9: While enable reads 1, writes to the control, start and length registers are ignored.
- R10: `done_pulse` is high for exactly one cycle, and that cycle is the first one in which enable reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| lookup_addr | output | 64 | Line address under ownership/presence check |
| lookup_hit | input | 1 | Line is owned and present |
| mreq_valid | output | 1 | Maintenance request valid |
| mreq_ready | input | 1 | Maintenance request accepted |
| mreq_addr | output | 64 | Line address of the request |
| done_pulse | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a register write that lands while a request is stalled mid-walk. Reaching it needs a hit on the first line and a ready signal that stays low long enough for the bus writes to arrive. The bench forces this by holding `mreq_ready` low under an all-hit lookup model. It then writes new start, length and control values, reads every register back, and releases ready to confirm that the original line sequence is unchanged. The carry of the end address across the 32-bit word boundary is reached with a directed start of 0xFFFFFF80.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

    typedef enum logic [1:0] {
        WALK_IDLE,
        WALK_PROBE,
        WALK_SEND,
        WALK_DONE
    } walk_state_t;

    localparam int          REG_AW        = 16;
    localparam logic [1:0]  OP_CLEAN_INV  = 2'd1;

    localparam logic [REG_AW-1:0] OFS_CTRL     = 16'h5004;
    localparam logic [REG_AW-1:0] OFS_START_LO = 16'h5008;
    localparam logic [REG_AW-1:0] OFS_START_HI = 16'h500C;
    localparam logic [REG_AW-1:0] OFS_LEN_LO   = 16'h5010;
    localparam logic [REG_AW-1:0] OFS_LEN_HI   = 16'h5014;

endpackage

// File: rtl/cmo_regfile.sv
module cmo_regfile
    import cmo_pkg::*;
#(
    parameter int REG_W  = 32,
    localparam int ADDR_W = 2 * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              finish,
    output logic              launch,
    output logic [1:0]        go_type,
    output logic              go_range,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] last_ofs
);

    logic       rng_q;
    logic [1:0] typ_q;
    logic       wr_ok;

    // writes are only accepted while no operation is running
    assign wr_ok    = reg_wr && !busy;
    assign launch   = wr_ok && (reg_addr == OFS_CTRL) && reg_wdata[0];
    assign go_type  = reg_wdata[3:2];
    assign go_range = reg_wdata[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            rng_q      <= 1'b0;
            typ_q      <= 2'd0;
            start_addr <= '0;
            last_ofs   <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                busy <= 1'b0;
            end
            if (wr_ok) begin
                unique case (reg_addr)
                    OFS_CTRL: begin
                        busy  <= reg_wdata[0];
                        rng_q <= reg_wdata[1];
                        typ_q <= reg_wdata[3:2];
                    end
                    OFS_START_LO: start_addr[REG_W-1:0]      <= reg_wdata;
                    OFS_START_HI: start_addr[ADDR_W-1:REG_W] <= reg_wdata;
                    OFS_LEN_LO:   last_ofs[REG_W-1:0]        <= reg_wdata;
                    OFS_LEN_HI:   last_ofs[ADDR_W-1:REG_W]   <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_CTRL:     reg_rdata = {{(REG_W-4){1'b0}}, typ_q, rng_q, busy};
            OFS_START_LO: reg_rdata = start_addr[REG_W-1:0];
            OFS_START_HI: reg_rdata = start_addr[ADDR_W-1:REG_W];
            OFS_LEN_LO:   reg_rdata = last_ofs[REG_W-1:0];
            OFS_LEN_HI:   reg_rdata = last_ofs[ADDR_W-1:REG_W];
            default:      reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cmo_line_walker.sv
module cmo_line_walker
    import cmo_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int LINE_BYTES = 128,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [1:0]        go_type,
    input  logic              go_range,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] last_ofs,
    input  logic              lookup_hit,
    input  logic              mreq_ready,
    output logic [ADDR_W-1:0] line_addr,
    output logic              mreq_valid,
    output logic              finish
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(LINE_BYTES);

    walk_state_t       state_q, state_d;
    logic [ADDR_W-1:0] cur_q, last_q;
    logic              at_last;
    logic              advance;

    function automatic logic [ADDR_W-1:0] line_of(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    endfunction

    assign at_last = (cur_q == last_q);
    assign advance = ((state_q == WALK_PROBE) && !lookup_hit && !at_last) ||
                     ((state_q == WALK_SEND) && mreq_ready && !at_last);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WALK_IDLE: begin
                if (launch) begin
                    state_d = (go_type == OP_CLEAN_INV) ? WALK_PROBE : WALK_DONE;
                end
            end
            WALK_PROBE: begin
                if (lookup_hit)   state_d = WALK_SEND;
                else if (at_last) state_d = WALK_DONE;
            end
            WALK_SEND: begin
                if (mreq_ready) state_d = at_last ? WALK_DONE : WALK_PROBE;
            end
            WALK_DONE: state_d = WALK_IDLE;
            default:   state_d = WALK_IDLE;
        endcase
    end

    // state register and line cursor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WALK_IDLE;
            cur_q   <= '0;
            last_q  <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == WALK_IDLE) && launch) begin
                cur_q  <= line_of(start_addr);
                last_q <= go_range ? line_of(start_addr + last_ofs)
                                   : line_of(start_addr);
            end else if (advance) begin
                cur_q <= cur_q + STEP;
            end
        end
    end

    // outputs
    always_comb begin
        line_addr  = cur_q;
        mreq_valid = 1'b0;
        finish     = 1'b0;
        unique case (state_q)
            WALK_SEND: mreq_valid = 1'b1;
            WALK_DONE: finish     = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/cmo_range_walker.sv
module cmo_range_walker
    import cmo_pkg::*;
#(
    parameter int REG_W      = 32,
    parameter int LINE_BYTES = 128,
    localparam int ADDR_W    = 2 * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [ADDR_W-1:0] lookup_addr,
    input  logic              lookup_hit,
    output logic              mreq_valid,
    input  logic              mreq_ready,
    output logic [ADDR_W-1:0] mreq_addr,
    output logic              done_pulse
);

    logic              launch, go_range, busy, finish;
    logic [1:0]        go_type;
    logic [ADDR_W-1:0] start_addr, last_ofs, line_addr;

    cmo_regfile #(.REG_W(REG_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .finish     (finish),
        .launch     (launch),
        .go_type    (go_type),
        .go_range   (go_range),
        .busy       (busy),
        .done       (done_pulse),
        .start_addr (start_addr),
        .last_ofs   (last_ofs)
    );

    cmo_line_walker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) walk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .go_type    (go_type),
        .go_range   (go_range),
        .start_addr (start_addr),
        .last_ofs   (last_ofs),
        .lookup_hit (lookup_hit),
        .mreq_ready (mreq_ready),
        .line_addr  (line_addr),
        .mreq_valid (mreq_valid),
        .finish     (finish)
    );

    assign lookup_addr = line_addr;
    assign mreq_addr   = line_addr;

endmodule

// File: rtl/cmo_range_walker_chk.sv
module cmo_range_walker_chk #(
    parameter int ADDR_W     = 64,
    parameter int LINE_BYTES = 128,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done_pulse,
    input logic              mreq_valid,
    input logic              mreq_ready,
    input logic [ADDR_W-1:0] mreq_addr
);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr)));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // R10
    done_at_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_pulse);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> !busy);

    // R3
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid |-> busy);

    // R4
    req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid |-> (mreq_addr[OFF_W-1:0] == '0));

endmodule

bind cmo_range_walker cmo_range_walker_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done_pulse (done_pulse),
    .mreq_valid (mreq_valid),
    .mreq_ready (mreq_ready),
    .mreq_addr  (mreq_addr)
);

// File: tb/cmo_range_walker_tb_top.sv
module cmo_range_walker_tb_top;

    localparam logic [15:0] A_CTRL = 16'h5004;
    localparam logic [15:0] A_SLO  = 16'h5008;
    localparam logic [15:0] A_SHI  = 16'h500C;
    localparam logic [15:0] A_LLO  = 16'h5010;
    localparam logic [15:0] A_LHI  = 16'h5014;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = 16'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [63:0] lookup_addr, mreq_addr;
    logic        lookup_hit, mreq_valid, done_pulse;
    logic        mreq_ready = 1'b1;

    int hmode = 0;
    int rmode = 0;
    int tick = 0;
    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] got_q[$];
    logic [63:0] exp_q[$];

    always #10 clk = ~clk;

    function automatic logic hitf(input logic [63:0] a, input int m);
        if (m == 0) return 1'b1;
        if (m == 1) return !(a[8] && a[7]);
        return 1'b0;
    endfunction

    assign lookup_hit = hitf(lookup_addr, hmode);

    cmo_range_walker dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lookup_addr(lookup_addr),
        .lookup_hit(lookup_hit), .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
        .mreq_addr(mreq_addr), .done_pulse(done_pulse)
    );

    always @(negedge clk) begin
        tick <= tick + 1;
        if (rmode == 0)      mreq_ready <= 1'b1;
        else if (rmode == 1) mreq_ready <= (tick % 3 == 1);
        else                 mreq_ready <= 1'b0;
    end

    always @(posedge clk) if (mreq_valid && mreq_ready) got_q.push_back(mreq_addr);

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        if (tick > 195000) begin
            n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp<195000", tick);
            summary();
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic launch(input logic [63:0] s, input logic [63:0] l, input logic rng, input logic [1:0] ty);
        wr(A_SLO, s[31:0]); wr(A_SHI, s[63:32]);
        wr(A_LLO, l[31:0]); wr(A_LHI, l[63:32]);
        got_q.delete();
        wr(A_CTRL, {28'h0, ty, rng, 1'b1});
    endtask

    // Polls enable, checks the done pulse, compares the request stream with exp_q
    task automatic finish_op(input string tag);
        logic [31:0] d;
        int n = 0;
        rd(A_CTRL, d);
        while (d[0] && n < 3000) begin
            @(negedge clk); rd(A_CTRL, d); n++;
        end
        check(!d[0], "R3 enable clears", d, 0);
        // R10: pulse in the first cycle enable reads 0, then gone
        check(done_pulse == 1'b1, "R10 done with clear", done_pulse, 1);
        @(negedge clk); #1;
        check(done_pulse == 1'b0, "R10 single pulse", done_pulse, 0);
        check(got_q.size() == exp_q.size(), {tag, " count"}, got_q.size(), exp_q.size());
        if (got_q.size() == exp_q.size())
            for (int i = 0; i < exp_q.size(); i++)
                check(got_q[i] == exp_q[i], {tag, " line"}, got_q[i], exp_q[i]);
    endtask

    task automatic build_exp(input logic [63:0] s, input logic [63:0] l, input logic rng, input logic [1:0] ty);
        logic [63:0] a, hi;
        exp_q.delete();
        if (ty != 2'd1) return;
        a  = s & ~64'h7F;
        hi = rng ? ((s + l) & ~64'h7F) : a;
        forever begin
            if (hitf(a, hmode)) exp_q.push_back(a);
            if (a == hi) break;
            a = a + 64'd128;
        end
    endtask

    task automatic run(input logic [63:0] s, input logic [63:0] l, input logic rng, input logic [1:0] ty, input string tag);
        build_exp(s, l, rng, ty);
        launch(s, l, rng, ty);
        finish_op(tag);
    endtask

    logic [63:0] starts[5] = '{64'h0, 64'h5, 64'h7F, 64'h80, 64'h3F81};
    logic [63:0] lens[8]   = '{64'd0, 64'd1, 64'd126, 64'd127, 64'd128, 64'd255, 64'd256, 64'd1000};

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(A_CTRL, d); check(d == 0, "R1 ctrl", d, 0);
        rd(A_SLO, d);  check(d == 0, "R1 start", d, 0);
        rd(A_LHI, d);  check(d == 0, "R1 len", d, 0);
        check(!mreq_valid && !done_pulse, "R1 outputs", {mreq_valid, done_pulse}, 0);

        // R2 map: ctrl write with enable clear stores fields only
        wr(A_CTRL, 32'hE);
        wr(A_SHI, 32'h1234_5678);
        wr(A_LLO, 32'h0BAD_F00D);
        rd(A_CTRL, d);   check(d == 32'hE, "R2 ctrl fields", d, 32'hE);
        rd(A_SHI, d);    check(d == 32'h1234_5678, "R2 start hi", d, 32'h1234_5678);
        rd(A_LLO, d);    check(d == 32'h0BAD_F00D, "R2 len lo", d, 32'h0BAD_F00D);
        rd(16'h5000, d); check(d == 0, "R2 unmapped", d, 0);
        repeat (3) @(negedge clk);
        check(got_q.size() == 0 && !mreq_valid, "R2 no launch", got_q.size(), 0);

        // R4 R5 R6 R7 sweep for clean-and-invalidate
        for (int h = 0; h < 3; h++)
            for (int r = 0; r < 2; r++)
                for (int si = 0; si < 5; si++)
                    for (int li = 0; li < 8; li++)
                        for (int rg = 0; rg < 2; rg++) begin
                            hmode = h; rmode = r;
                            run(starts[si], lens[li], rg[0], 2'd1,
                                rg ? "R4 R6 R7 range" : "R5 single");
                        end

        // R8 other types issue nothing
        hmode = 0; rmode = 0;
        for (int t = 0; t < 4; t++)
            if (t != 1)
                for (int si = 0; si < 5; si++)
                    for (int li = 0; li < 8; li += 3)
                        run(starts[si], lens[li], 1'b1, t[1:0], "R8 other type");

        // R4 end address carries into the high word
        run(64'h0000_0000_FFFF_FF80, 64'd255, 1'b1, 2'd1, "R4 carry");
        run(64'h0000_0002_0000_0010, 64'd300, 1'b1, 2'd1, "R4 high start");

        // R9 writes ignored during a stalled walk (R7 request held)
        hmode = 0; rmode = 2;
        build_exp(64'h1000, 64'h17F, 1'b1, 2'd1);
        launch(64'h1000, 64'h17F, 1'b1, 2'd1);
        repeat (4) @(negedge clk);
        #1;
        check(mreq_valid && mreq_addr == 64'h1000, "R7 stalled request", mreq_addr, 64'h1000);
        wr(A_SLO, 32'hDEAD_0000);
        wr(A_LLO, 32'h5);
        wr(A_CTRL, 32'h0);
        rd(A_SLO, d);  check(d == 32'h1000, "R9 start kept", d, 32'h1000);
        rd(A_LLO, d);  check(d == 32'h17F, "R9 len kept", d, 32'h17F);
        rd(A_CTRL, d); check(d == 32'h7, "R9 ctrl kept", d, 32'h7);
        check(mreq_valid && mreq_addr == 64'h1000, "R7 R9 still held", mreq_addr, 64'h1000);
        rmode = 0;
        finish_op("R9 walk unchanged");

        summary();
        $finish;
    end

endmodule